// File: doc/BRIEF.md
# UART Transmit Queue Controller

This block sits between the host side of a UART and its serial line encoder. It takes each byte that the host writes to the transmit data port and routes it along one of three paths. If the shifter is idle, the byte loads straight into the shift register. If the shifter is busy and FIFO mode is on, the byte goes into a transmit FIFO. If the shifter is busy and FIFO mode is off (polled mode), the byte goes into a single holding register.

A character-time tick comes from the baud logic. On each tick the block presents the current shifter content as a one-cycle strobe with its data, then reloads the shifter from the FIFO or the holding register. The block keeps two status flags. One shows that the transmitter is empty. The other asks the host for more data. In FIFO mode the data-request flag follows a half-full threshold, not emptiness.

When the send-break control is released, the block queues a break marker. The marker is a ninth flag bit that travels beside the data, so the encoder can tell it apart from a real zero byte.

Top module: `uart_txq_ctrl`

## Requirements
- R1: After reset, `tx_empty` and `data_req` read 1 and `out_valid` reads 0.
- R2: A write that arrives while `tx_empty` is 1 loads the shifter directly, without using the FIFO. `tx_empty` reads 0 after the next clock edge.
- R3: In FIFO mode, a write that arrives while the shifter is busy is appended to the FIFO. `data_req` clears as soon as occupancy exceeds DEPTH/2 (9 of 16 by default).
- R4: In FIFO mode, a tick while the shifter is busy emits the shifter and reloads it from the FIFO head. Bytes leave in write order. `data_req` sets once at most DEPTH/2 entries remain. If the FIFO was empty at the tick, `tx_empty` sets instead.
- R5: In polled mode, a write that arrives while the shifter is busy is stored in the holding register only when `data_req` is 1, and `data_req` then clears. If `data_req` is 0, the write is dropped.
- R6: In polled mode, a tick while the shifter is busy emits the shifter. If a byte is held, the shifter reloads from the holding register and `data_req` sets. If no byte is held, `tx_empty` sets.
- R7: A 1-to-0 change of `brk_ctl` queues a marker along the normal write path. The marker is emitted with `out_brk`=1 and `out_data`=0. A host write in the same cycle is dropped. A 0-to-1 change of `brk_ctl` has no effect.
- R8: Any of three events flushes the transmitter: a `fifo_clr` pulse, a 1-to-0 change of `fifo_en`, or a 0-to-1 change of `unit_on`. A flush discards the FIFO, the shifter and the holding register, and sets both `tx_empty` and `data_req`. A write or tick in the same cycle is discarded.
- R9: A write to a full FIFO is dropped, and the stored entries still leave in order.
- R10: A tick while `tx_empty` is 1 produces no output strobe.
- R11: `out_valid` is a single-cycle strobe. It is registered one cycle after the tick that caused it.
- R12: When a tick and a write arrive in the same cycle, the tick is handled first, and the write sees the state the tick left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_on | input | 1 | Unit enable level; its rising edge flushes |
| fifo_en | input | 1 | FIFO mode level; its falling edge flushes |
| fifo_clr | input | 1 | Transmit FIFO clear pulse |
| brk_ctl | input | 1 | Send-break level; its falling edge queues a marker |
| wr_valid | input | 1 | Host write strobe for the data port |
| wr_data | input | DATA_W | Host write byte |
| char_tick | input | 1 | Character-time tick |
| out_valid | output | 1 | Character strobe to the line encoder |
| out_data | output | DATA_W | Character data |
| out_brk | output | 1 | Character is a break marker |
| tx_empty | output | 1 | Transmitter-empty flag |
| data_req | output | 1 | Transmit data-request flag |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `fifo_en` is not raised while polled mode still holds a byte, because in that case the meaning of the request flag would change under the held byte. The stimulus changes inputs only just after a rising edge. It switches modes only after a flush or once the transmitter has drained. It applies the same-cycle cases (tick with write, break with write, flush with data pending) on purpose, so the ordering rules are exercised rather than avoided.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  // True when an occupancy lies strictly above half the FIFO depth.
  function automatic logic over_half(input int occ, input int depth);
    return occ > (depth / 2);
  endfunction

  // Next index of a circular buffer, with wrap for any depth.
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/uart_txq_edge.sv
module uart_txq_edge #(
  parameter int N = 3,
  parameter logic [N-1:0] ON_RISE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (ON_RISE[i]) begin : g_rise
      assign evt[i] = lvl[i] & ~prev[i];
    end else begin : g_fall
      assign evt[i] = ~lvl[i] & prev[i];
    end
  end
endmodule

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  import uart_txq_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok, accept, is_full;

  assign is_full = (count == CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign accept  = push && (!is_full || pop_ok);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop_ok) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      count <= count + CW'(accept) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !clr) mem[wr_ptr] <= push_data;
  end

  // R9: occupancy never exceeds the depth
  p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9: a push into a full FIFO without a pop leaves it exactly full
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && is_full && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_on,
  input  logic              fifo_en,
  input  logic              fifo_clr,
  input  logic              brk_ctl,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              char_tick,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_brk,
  output logic              tx_empty,
  output logic              data_req
);
  import uart_txq_pkg::*;
  localparam int EW = DATA_W + 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] EDGE_RISE = 3'b001;

  logic [2:0]    evt;
  logic          flush, brk_evt, w_valid, tick_fire;
  logic [EW-1:0] w_ent;
  logic [EW-1:0] shifter, shifter_n, hold, hold_n;
  logic          empty_n, req_n, emit, push, pop;
  logic [EW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;

  // evt[0]: unit on rising, evt[1]: fifo mode falling, evt[2]: break release
  uart_txq_edge #(.N(3), .ON_RISE(EDGE_RISE)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({brk_ctl, fifo_en, unit_on}),
    .evt(evt)
  );

  assign flush     = fifo_clr | evt[1] | evt[0];
  assign brk_evt   = evt[2];
  assign w_valid   = brk_evt | wr_valid;
  assign w_ent     = brk_evt ? {1'b1, {DATA_W{1'b0}}} : {1'b0, wr_data};
  assign tick_fire = char_tick & ~tx_empty;

  uart_txq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(flush),
    .push(push), .push_data(w_ent), .pop(pop),
    .head(fifo_head), .count(fifo_cnt)
  );

  always_comb begin
    shifter_n = shifter;
    hold_n    = hold;
    empty_n   = tx_empty;
    req_n     = data_req;
    emit      = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    if (flush) begin
      empty_n = 1'b1;
      req_n   = 1'b1;
    end else begin
      // tick first (R12)
      if (tick_fire) begin
        emit = 1'b1;
        if (fifo_en) begin
          if (fifo_cnt != '0) begin
            shifter_n = fifo_head;
            pop       = 1'b1;
            if (!over_half(int'(fifo_cnt) - 1, DEPTH)) req_n = 1'b1;
          end else begin
            empty_n = 1'b1;
          end
        end else if (data_req) begin
          empty_n = 1'b1;
        end else begin
          shifter_n = hold;
          req_n     = 1'b1;
        end
      end
      // then the write sees the post-tick state
      if (w_valid) begin
        if (empty_n) begin
          shifter_n = w_ent;
          empty_n   = 1'b0;
        end else if (fifo_en) begin
          push = 1'b1;
          if (over_half(int'(fifo_cnt) - int'(pop) + 1, DEPTH)) req_n = 1'b0;
        end else if (req_n) begin
          hold_n = w_ent;
          req_n  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifter   <= '0;
      hold      <= '0;
      tx_empty  <= 1'b1;
      data_req  <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_brk   <= 1'b0;
    end else begin
      shifter   <= shifter_n;
      hold      <= hold_n;
      tx_empty  <= empty_n;
      data_req  <= req_n;
      out_valid <= emit;
      if (emit) begin
        out_data <= shifter[DATA_W-1:0];
        out_brk  <= shifter[DATA_W];
      end
    end
  end

  p_flush_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_empty && data_req && !out_valid));

  p_idle_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && w_valid && !flush) |=> !tx_empty);

  p_strobe_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(char_tick));

  p_idle_tick_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (char_tick && tx_empty) |=> !out_valid);

  p_polled_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !tx_empty && !data_req && !char_tick && w_valid && !flush)
      |=> ($stable(hold) && !data_req));

  p_fifo_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && !tx_empty && w_valid && !char_tick &&
     over_half(int'(fifo_cnt) + 1, DEPTH)) |=> !data_req);
endmodule

// File: tb/uart_txq_ctrl_test.sv
module uart_txq_ctrl_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int NV = 10;
  // {wr, data[8], tick, exp_valid, exp_data[8], exp_empty, exp_req}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hC3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b1},
    {1'b1, 8'hD4, 1'b1, 1'b1, 8'hB2, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hD4, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'hE5, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hE5, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic unit_on = 0, fifo_en = 1, fifo_clr = 0, brk_ctl = 0;
  logic wr_valid = 0, char_tick = 0;
  logic [DW-1:0] wr_data = '0;
  logic out_valid, out_brk, tx_empty, data_req;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_txq_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .unit_on(unit_on), .fifo_en(fifo_en),
    .fifo_clr(fifo_clr), .brk_ctl(brk_ctl), .wr_valid(wr_valid),
    .wr_data(wr_data), .char_tick(char_tick), .out_valid(out_valid),
    .out_data(out_data), .out_brk(out_brk), .tx_empty(tx_empty),
    .data_req(data_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    wr_valid = 0; char_tick = 0; fifo_clr = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic tk);
    wr_valid = 1; wr_data = d; char_tick = tk; cyc();
  endtask

  task automatic tick();
    char_tick = 1; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1", "tx_empty", 32'(tx_empty), 1);
    chk("R1", "data_req", 32'(data_req), 1);
    chk("R1", "out_valid", 32'(out_valid), 0);
    rst_n = 1;
    cyc();

    // table walk: FIFO mode, R2 R4 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      wr_valid = v[20]; wr_data = v[19:12]; char_tick = v[11];
      cyc();
      chk("R11", $sformatf("row%0d out_valid", i), 32'(out_valid), 32'(v[10]));
      if (v[10]) chk("R4", $sformatf("row%0d out_data", i), 32'(out_data), 32'(v[9:2]));
      chk("R2", $sformatf("row%0d tx_empty", i), 32'(tx_empty), 32'(v[1]));
      chk("R12", $sformatf("row%0d data_req", i), 32'(data_req), 32'(v[0]));
    end

    // R3 / R9 / R4: fill beyond full then drain
    put(8'h10, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      put(8'(8'h10 + k), 0);
      chk("R3", $sformatf("req after %0d pushes", k), 32'(data_req), 32'(k <= DEPTH/2));
    end
    put(8'h5A, 0);
    put(8'h5B, 0);
    chk("R9", "req when full", 32'(data_req), 0);
    for (int i = 1; i <= DEPTH + 1; i++) begin
      tick();
      chk("R9", $sformatf("drain %0d valid", i), 32'(out_valid), 1);
      chk("R4", $sformatf("drain %0d data", i), 32'(out_data), 32'(8'h10 + i - 1));
      if (i <= DEPTH)
        chk("R4", $sformatf("drain %0d req", i), 32'(data_req), 32'((DEPTH - i) <= DEPTH/2));
    end
    chk("R4", "empty after drain", 32'(tx_empty), 1);
    tick();
    chk("R10", "no strobe when empty", 32'(out_valid), 0);

    // R8: clear pulse with data pending
    put(8'h31, 0); put(8'h32, 0); put(8'h33, 0);
    fifo_clr = 1; wr_valid = 1; wr_data = 8'h34; cyc();
    chk("R8", "clr empty", 32'(tx_empty), 1);
    chk("R8", "clr req", 32'(data_req), 1);
    tick();
    chk("R8", "no output after clr", 32'(out_valid), 0);
    put(8'h55, 0);
    tick();
    chk("R8", "fresh byte out", 32'(out_data), 32'h55);
    tick();
    chk("R8", "old entries gone", 32'(out_valid), 0);
    // R8: unit enable rising edge
    put(8'h66, 0);
    unit_on = 1; cyc();
    chk("R8", "unit_on empty", 32'(tx_empty), 1);
    tick();
    chk("R8", "unit_on no output", 32'(out_valid), 0);

    // R8 via fifo disable, then polled mode R5 R6
    put(8'h77, 0);
    fifo_en = 0; cyc();
    chk("R8", "fifo off empty", 32'(tx_empty), 1);
    chk("R8", "fifo off req", 32'(data_req), 1);
    put(8'h81, 0);
    put(8'h82, 0);
    chk("R5", "hold clears req", 32'(data_req), 0);
    put(8'h83, 0);
    chk("R5", "drop keeps req 0", 32'(data_req), 0);
    tick();
    chk("R6", "polled emit", 32'(out_data), 32'h81);
    chk("R6", "req set on reload", 32'(data_req), 1);
    chk("R6", "still busy", 32'(tx_empty), 0);
    tick();
    chk("R5", "held byte not overwritten", 32'(out_data), 32'h82);
    chk("R6", "empty after last", 32'(tx_empty), 1);
    tick();
    chk("R5", "dropped byte never sent", 32'(out_valid), 0);

    // R7 break marker
    brk_ctl = 1; cyc();
    chk("R7", "break rise no effect", 32'(tx_empty), 1);
    brk_ctl = 0; wr_valid = 1; wr_data = 8'h99; cyc();
    chk("R7", "marker loaded", 32'(tx_empty), 0);
    tick();
    chk("R7", "marker strobe", 32'(out_valid), 1);
    chk("R7", "marker flag", 32'(out_brk), 1);
    chk("R7", "marker data", 32'(out_data), 0);
    tick();
    chk("R7", "host write dropped", 32'(out_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule